// File: doc/BRIEF.md
# Distributed CBR Refresh Scheduler

This block keeps an asynchronous page-mode DRAM refreshed by issuing CAS-before-RAS cycles at a fixed interval. Because the device's own row counter picks the row, no address is driven. An interval timer marks each refresh slot, and a saturating backlog counter records slots that have not yet been served. The block asks the access controller for the bus with a request line. Once it sees a grant, it takes the strobes and serves the whole backlog back-to-back before it hands the bus back.

For low-power retention, a self-refresh request makes the block hold both RAS and CAS low for at least a minimum time. It honours that request only when the backlog is empty. While the device refreshes itself, the interval timer is frozen. When the request drops, RAS and CAS return high for an exit precharge. One distributed refresh is then issued at once, and after that the bus is released. The default timing parameters assume a 100 MHz clock: one slot every 15.6 µs (4096 rows in 64 ms) and a 100 µs self-refresh minimum. For the low-power 128 ms period, the interval parameter is doubled.

Top module: `rfsh_cbr_sched`

## Requirements
- R1: After reset, ras_n_o, cas_n_o and we_n_o are high, own_o, req_o and sr_active_o are low, and backlog_o is zero.
- R2: Outside self-refresh, backlog_o rises by one every INTERVAL_CYC clock edges counted from reset release, and req_o is high whenever the block is idle with a nonzero backlog.
- R3: The backlog saturates at BACKLOG_MAX. Further slots are dropped and the count never exceeds the limit.
- R4: The block takes the bus (own_o rising) only on an edge where grant_i is high. While it does not own the bus, ras_n_o and cas_n_o stay high.
- R5: In every cycle, CAS falls exactly CSR_CYC cycles before RAS falls and stays low as long as RAS is low. we_n_o is high whenever RAS falls.
- R6: A distributed refresh holds RAS low for exactly RAS_CYC cycles. Between that RAS rise and the next CAS fall, both strobes stay high for at least RP_CYC cycles.
- R7: Once granted, the block keeps own_o high and serves refresh cycles back-to-back until the backlog is zero. Each completed cycle lowers the backlog by one, so the number of pulses plus the remaining backlog equals the number of elapsed slots.
- R8: Self-refresh starts only with a zero backlog. A grant that arrives with a pending backlog and an active self-refresh request serves the distributed refresh first.
- R9: In self-refresh, RAS stays low for at least SR_MIN_CYC cycles and for as long as sr_req_i stays high.
- R10: On self-refresh exit, both strobes stay high for at least SR_EXIT_CYC cycles. Exactly one distributed refresh follows, and then own_o falls.
- R11: The interval timer is frozen during self-refresh and restarts from zero when it ends, so the next slot lands INTERVAL_CYC edges after sr_active_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant_i | input | 1 | Bus grant from the access controller |
| sr_req_i | input | 1 | Self-refresh request, level |
| req_o | output | 1 | Bus request to the access controller |
| own_o | output | 1 | High while this block drives the strobes |
| sr_active_o | output | 1 | High during self-refresh entry, hold and exit |
| backlog_o | output | $clog2(BACKLOG_MAX+1) | Unserved refresh slots |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |

## Verification
A wrong sequencer state shows up on the strobes within one refresh cycle. The symptoms are a wrong CAS lead before the RAS fall, a RAS pulse of the wrong width, or a precharge that is too short before the next CAS fall. A miscounted backlog shows up only later, as the wrong number of back-to-back pulses in one ownership. It therefore needs the invariant that the pulses plus the remaining backlog equal the elapsed slots. A timer that runs during self-refresh stays hidden until the first slot after exit, which arrives early. The check therefore times that slot against the fall of sr_active_o.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAS_LEAD,
        ST_RAS_LOW,
        ST_PRECH,
        ST_SR_LEAD,
        ST_SR_HOLD,
        ST_SR_EXIT
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    localparam strobe_t STROBE_REST = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer
    import rfsh_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    output logic tick_o
);
    localparam int unsigned TW = bits_for(INTERVAL_CYC - 1);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

    logic [TW-1:0] cnt_q;

    assign tick_o = !hold_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || hold_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r11_count_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    a_r11_restart_after_hold: assert property (@(posedge clk) disable iff (rst)
        $past(hold_i) |-> cnt_q == '0);

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog
    import rfsh_pkg::*;
#(
    parameter int unsigned BACKLOG_MAX = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             slot_i,
    input  logic                             exit_i,
    input  logic                             served_i,
    output logic [bits_for(BACKLOG_MAX)-1:0] count_o,
    output logic                             nonzero_o
);
    localparam int unsigned BW = bits_for(BACKLOG_MAX);

    logic [BW-1:0] count_q;
    logic [BW+1:0] sum;
    logic [BW-1:0] count_d;

    always_comb begin
        sum = {2'b00, count_q} + (BW+2)'(slot_i || exit_i) - (BW+2)'(served_i);
        if (sum > (BW+2)'(BACKLOG_MAX)) begin
            count_d = BW'(BACKLOG_MAX);
        end else begin
            count_d = sum[BW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o   = count_q;
    assign nonzero_o = (count_q != '0);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count_q <= BW'(BACKLOG_MAX));

    a_r7_serve_needs_backlog: assert property (@(posedge clk) disable iff (rst)
        served_i |-> count_q != '0);

    a_r7_served_lowers_count: assert property (@(posedge clk) disable iff (rst)
        (served_i && !slot_i && !exit_i) |=> count_q == $past(count_q) - 1'b1);

endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
    import rfsh_pkg::*;
#(
    parameter int unsigned CSR_CYC     = 1,
    parameter int unsigned RAS_CYC     = 5,
    parameter int unsigned RP_CYC      = 4,
    parameter int unsigned SR_MIN_CYC  = 10000,
    parameter int unsigned SR_EXIT_CYC = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    grant_i,
    input  logic    sr_req_i,
    input  logic    pend_nz_i,
    output logic    req_o,
    output logic    own_o,
    output logic    sr_active_o,
    output logic    served_o,
    output logic    exit_o,
    output strobe_t strobe_o
);
    localparam int unsigned LMAX =
        max2(max2(max2(CSR_CYC, RAS_CYC), max2(RP_CYC, SR_MIN_CYC)), SR_EXIT_CYC);
    localparam int unsigned CW = bits_for(LMAX);

    localparam logic [CW-1:0] LD_CSR  = CW'(CSR_CYC - 1);
    localparam logic [CW-1:0] LD_RAS  = CW'(RAS_CYC - 1);
    localparam logic [CW-1:0] LD_RP   = CW'(RP_CYC - 1);
    localparam logic [CW-1:0] LD_SR   = CW'(SR_MIN_CYC - 1);
    localparam logic [CW-1:0] LD_EXIT = CW'(SR_EXIT_CYC - 1);

    seq_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_zero ? '0 : cnt_q - 1'b1;
        served_o = 1'b0;
        exit_o   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (grant_i && pend_nz_i) begin
                    st_d  = ST_CAS_LEAD;
                    cnt_d = LD_CSR;
                end else if (grant_i && sr_req_i) begin
                    st_d  = ST_SR_LEAD;
                    cnt_d = LD_CSR;
                end
            end
            ST_CAS_LEAD: begin
                if (cnt_zero) begin
                    st_d  = ST_RAS_LOW;
                    cnt_d = LD_RAS;
                end
            end
            ST_RAS_LOW: begin
                if (cnt_zero) begin
                    st_d     = ST_PRECH;
                    cnt_d    = LD_RP;
                    served_o = 1'b1;
                end
            end
            ST_PRECH: begin
                if (cnt_zero) begin
                    if (pend_nz_i) begin
                        st_d  = ST_CAS_LEAD;
                        cnt_d = LD_CSR;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
            ST_SR_LEAD: begin
                if (cnt_zero) begin
                    st_d  = ST_SR_HOLD;
                    cnt_d = LD_SR;
                end
            end
            ST_SR_HOLD: begin
                if (cnt_zero && !sr_req_i) begin
                    st_d  = ST_SR_EXIT;
                    cnt_d = LD_EXIT;
                end
            end
            ST_SR_EXIT: begin
                if (cnt_zero) begin
                    st_d   = ST_CAS_LEAD;
                    cnt_d  = LD_CSR;
                    exit_o = 1'b1;
                end
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        strobe_o = STROBE_REST;
        strobe_o.ras_n = !(st_q == ST_RAS_LOW || st_q == ST_SR_HOLD);
        strobe_o.cas_n = !(st_q == ST_CAS_LEAD || st_q == ST_RAS_LOW ||
                           st_q == ST_SR_LEAD  || st_q == ST_SR_HOLD);
    end

    assign own_o       = (st_q != ST_IDLE);
    assign sr_active_o = (st_q == ST_SR_LEAD || st_q == ST_SR_HOLD || st_q == ST_SR_EXIT);
    assign req_o       = (st_q == ST_IDLE) && (pend_nz_i || sr_req_i);

    // Run-length counters that let the width checks below avoid parameter-deep $past.
    int unsigned ras_low_run;
    int unsigned ras_high_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            ras_low_run  <= 0;
            ras_high_run <= SR_EXIT_CYC + RP_CYC;
        end else begin
            ras_low_run  <= strobe_o.ras_n ? 0 : ras_low_run + 1;
            ras_high_run <= strobe_o.ras_n ? ras_high_run + 1 : 0;
        end
    end

    a_r5_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_o.ras_n) |-> $past(!strobe_o.cas_n));

    a_r5_cas_covers_ras: assert property (@(posedge clk) disable iff (rst)
        !strobe_o.ras_n |-> !strobe_o.cas_n);

    a_r6_ras_width: assert property (@(posedge clk) disable iff (rst)
        ($rose(strobe_o.ras_n) && !sr_active_o) |-> ras_low_run == RAS_CYC);

    a_r6_precharge: assert property (@(posedge clk) disable iff (rst)
        ($fell(strobe_o.cas_n) && !sr_active_o) |-> ras_high_run >= RP_CYC);

    a_r9_sr_width: assert property (@(posedge clk) disable iff (rst)
        ($rose(strobe_o.ras_n) && sr_active_o) |-> ras_low_run >= SR_MIN_CYC);

    a_r9_hold_while_req: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q == ST_SR_HOLD) && $past(sr_req_i)) |-> st_q == ST_SR_HOLD);

endmodule

// File: rtl/rfsh_cbr_sched.sv
module rfsh_cbr_sched
    import rfsh_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = 1560,
    parameter int unsigned CSR_CYC      = 1,
    parameter int unsigned RAS_CYC      = 5,
    parameter int unsigned RP_CYC       = 4,
    parameter int unsigned SR_MIN_CYC   = 10000,
    parameter int unsigned SR_EXIT_CYC  = 8,
    parameter int unsigned BACKLOG_MAX  = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             grant_i,
    input  logic                             sr_req_i,
    output logic                             req_o,
    output logic                             own_o,
    output logic                             sr_active_o,
    output logic [$clog2(BACKLOG_MAX+1)-1:0] backlog_o,
    output logic                             ras_n_o,
    output logic                             cas_n_o,
    output logic                             we_n_o
);
    localparam int unsigned BW = bits_for(BACKLOG_MAX);

    logic          slot;
    logic          served;
    logic          sr_exit;
    logic          pend_nz;
    logic          sr_busy;
    logic [BW-1:0] count;
    strobe_t       strobe;

    rfsh_interval_timer #(
        .INTERVAL_CYC(INTERVAL_CYC)
    ) i_timer (
        .clk   (clk),
        .rst   (rst),
        .hold_i(sr_busy),
        .tick_o(slot)
    );

    rfsh_backlog #(
        .BACKLOG_MAX(BACKLOG_MAX)
    ) i_backlog (
        .clk      (clk),
        .rst      (rst),
        .slot_i   (slot),
        .exit_i   (sr_exit),
        .served_i (served),
        .count_o  (count),
        .nonzero_o(pend_nz)
    );

    rfsh_strobe_seq #(
        .CSR_CYC    (CSR_CYC),
        .RAS_CYC    (RAS_CYC),
        .RP_CYC     (RP_CYC),
        .SR_MIN_CYC (SR_MIN_CYC),
        .SR_EXIT_CYC(SR_EXIT_CYC)
    ) i_seq (
        .clk        (clk),
        .rst        (rst),
        .grant_i    (grant_i),
        .sr_req_i   (sr_req_i),
        .pend_nz_i  (pend_nz),
        .req_o      (req_o),
        .own_o      (own_o),
        .sr_active_o(sr_busy),
        .served_o   (served),
        .exit_o     (sr_exit),
        .strobe_o   (strobe)
    );

    assign sr_active_o = sr_busy;
    assign backlog_o   = count;
    assign ras_n_o     = strobe.ras_n;
    assign cas_n_o     = strobe.cas_n;
    assign we_n_o      = strobe.we_n;

    a_r4_own_needs_grant: assert property (@(posedge clk) disable iff (rst)
        $rose(own_o) |-> $past(grant_i));

    a_r8_sr_needs_empty: assert property (@(posedge clk) disable iff (rst)
        $rose(sr_active_o) |-> $past(count == '0));

    a_r11_timer_frozen: assert property (@(posedge clk) disable iff (rst)
        sr_active_o |-> !slot);

    a_r10_one_refresh_after_exit: assert property (@(posedge clk) disable iff (rst)
        sr_exit |=> (own_o && !cas_n_o && ras_n_o));

endmodule

// File: tb/test_rfsh_cbr_sched.sv
module test_rfsh_cbr_sched;
    localparam int INTERVAL = 20;
    localparam int CSR      = 2;
    localparam int RAS      = 3;
    localparam int RP       = 2;
    localparam int SRMIN    = 10;
    localparam int SREXIT   = 3;
    localparam int BMAX     = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       grant_i = 1'b0;
    logic       sr_req_i = 1'b0;
    logic       req_o, own_o, sr_active_o, ras_n_o, cas_n_o, we_n_o;
    logic [3:0] backlog_o;

    int checks = 0;
    int errors = 0;

    rfsh_cbr_sched #(
        .INTERVAL_CYC(INTERVAL), .CSR_CYC(CSR), .RAS_CYC(RAS), .RP_CYC(RP),
        .SR_MIN_CYC(SRMIN), .SR_EXIT_CYC(SREXIT), .BACKLOG_MAX(BMAX)
    ) i_rfsh_cbr_sched (
        .clk(clk), .rst(rst), .grant_i(grant_i), .sr_req_i(sr_req_i),
        .req_o(req_o), .own_o(own_o), .sr_active_o(sr_active_o),
        .backlog_o(backlog_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Port monitor, sampled 2 ns after each rising edge.
    int  edge_cnt, pulses, own_rises, last_sr_len;
    int  cas_low_run, ras_low_run, ras_high_run;
    logic prev_ras, prev_cas, prev_own, last_was_sr;

    always begin
        @(posedge clk);
        #2;
        if (rst) begin
            edge_cnt = 0; pulses = 0; own_rises = 0; last_sr_len = 0;
            cas_low_run = 0; ras_low_run = 0; ras_high_run = 1000;
            prev_ras = 1'b1; prev_cas = 1'b1; prev_own = 1'b0; last_was_sr = 1'b0;
        end else begin
            edge_cnt++;
            if (own_o && !prev_own) begin
                own_rises++;
                chk(grant_i == 1'b1, "R4 own without grant", int'(grant_i), 1);
            end
            if (!own_o) chk(ras_n_o && cas_n_o, "R4 strobes idle when not owning",
                            int'({ras_n_o, cas_n_o}), 3);
            if (!ras_n_o && prev_ras) begin
                chk(cas_low_run == CSR, "R5 CAS lead", cas_low_run, CSR);
                chk(we_n_o == 1'b1, "R5 W high at RAS fall", int'(we_n_o), 1);
            end
            if (!ras_n_o) chk(!cas_n_o, "R5 CAS low under RAS", int'(cas_n_o), 0);
            if (ras_n_o && !prev_ras) begin
                if (sr_active_o) begin
                    chk(ras_low_run >= SRMIN, "R9 self-refresh RAS width", ras_low_run, SRMIN);
                    last_sr_len = ras_low_run;
                    last_was_sr = 1'b1;
                end else begin
                    chk(ras_low_run == RAS, "R6 RAS width", ras_low_run, RAS);
                    pulses++;
                    last_was_sr = 1'b0;
                end
            end
            if (!cas_n_o && prev_cas) begin
                if (last_was_sr)
                    chk(ras_high_run >= SREXIT, "R10 exit precharge", ras_high_run, SREXIT);
                else
                    chk(ras_high_run >= RP, "R6 precharge", ras_high_run, RP);
            end
            cas_low_run  = cas_n_o ? 0 : cas_low_run + 1;
            ras_low_run  = ras_n_o ? 0 : ras_low_run + 1;
            ras_high_run = ras_n_o ? ras_high_run + 1 : 0;
            prev_ras = ras_n_o; prev_cas = cas_n_o; prev_own = own_o;
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 60000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 60000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; grant_i = 1'b0; sr_req_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        // R1: reset state
        do_reset();
        chk(ras_n_o && cas_n_o && we_n_o, "R1 strobes high", int'({ras_n_o, cas_n_o, we_n_o}), 7);
        chk(!own_o && !req_o && !sr_active_o, "R1 control low",
            int'({own_o, req_o, sr_active_o}), 0);
        chk(backlog_o == 0, "R1 backlog", backlog_o, 0);

        // R2 / R3: slot accumulation without grant, every edge
        for (int i = 1; i <= 200; i++) begin
            int exp;
            @(negedge clk);
            exp = (i / INTERVAL > BMAX) ? BMAX : i / INTERVAL;
            if (i < BMAX * INTERVAL)
                chk(backlog_o == exp, "R2 backlog per slot", backlog_o, exp);
            else
                chk(backlog_o == exp, "R3 backlog saturates", backlog_o, exp);
            chk(req_o == (exp != 0), "R2 request", int'(req_o), int'(exp != 0));
        end

        // R7: drain a full backlog in one ownership
        do_reset();
        repeat (BMAX * INTERVAL) @(negedge clk);
        chk(backlog_o == BMAX, "R7 backlog before grant", backlog_o, BMAX);
        grant_i = 1'b1;
        while (!own_o) @(negedge clk);
        grant_i = 1'b0;
        while (own_o) @(negedge clk);
        chk(own_rises == 1, "R7 single ownership", own_rises, 1);
        chk(backlog_o == 0, "R7 drained", backlog_o, 0);
        chk(pulses + backlog_o == edge_cnt / INTERVAL, "R7 pulses plus backlog",
            pulses + backlog_o, edge_cnt / INTERVAL);
        chk(pulses >= BMAX, "R7 pulse count", pulses, BMAX);

        // R4: self-refresh request without grant does nothing
        do_reset();
        sr_req_i = 1'b1;
        @(negedge clk);
        chk(req_o == 1'b1, "R4 request for self-refresh", int'(req_o), 1);
        repeat (15) @(negedge clk);
        chk(!own_o && !sr_active_o, "R4 no entry without grant",
            int'({own_o, sr_active_o}), 0);

        // R8..R11: self-refresh with short and long requests
        for (int pass = 0; pass < 2; pass++) begin
            int hold_len;
            int base;
            hold_len = (pass == 0) ? 4 : 25;
            do_reset();
            repeat (INTERVAL) @(negedge clk);
            chk(backlog_o == 1, "R8 backlog pending", backlog_o, 1);
            sr_req_i = 1'b1;
            grant_i  = 1'b1;
            while (ras_n_o) @(negedge clk);
            chk(!sr_active_o, "R8 refresh before self-refresh", int'(sr_active_o), 0);
            while (!sr_active_o) @(negedge clk);
            chk(backlog_o == 0, "R8 empty at entry", backlog_o, 0);
            grant_i = 1'b0;
            repeat (hold_len) @(negedge clk);
            sr_req_i = 1'b0;
            while (sr_active_o) @(negedge clk);
            chk(last_sr_len >= ((hold_len - 1 > SRMIN) ? hold_len - 1 : SRMIN),
                "R9 held while requested", last_sr_len,
                (hold_len - 1 > SRMIN) ? hold_len - 1 : SRMIN);
            base = pulses;
            repeat (INTERVAL - 1) @(negedge clk);
            chk(pulses - base == 1, "R10 one refresh after exit", pulses - base, 1);
            chk(!own_o, "R10 bus released", int'(own_o), 0);
            chk(backlog_o == 0, "R11 no slot before interval", backlog_o, 0);
            @(negedge clk);
            chk(backlog_o == 1, "R11 slot one interval after exit", backlog_o, 1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule